// File: doc/BRIEF.md
# Prescaled 8-bit Timer with Variable Top

The block is a small timer/counter for a peripheral subsystem. A free-running prescaler produces a tick enable at one of several power-of-two rates. An 8-bit counter advances only on that enable. It counts in one of three ways:
- free up-counting that wraps at the all-ones value;
- up-counting that wraps at a programmable top;
- a phase-correct triangle that climbs to the top and falls back to zero.

Software reaches the block through a flat register port with single-cycle writes and a combinational read. Through it, software sets the mode and the rate, loads the count, and programs three compare values. The third compare value serves as the programmable top. Software can also read and clear the event flags and set the interrupt masks.

The block raises three sticky event flags: wrap (overflow), compare A and compare B. A flag is cleared by writing a one to its bit. Each interrupt request is its flag gated by its mask bit. The block also exports a one-cycle match pulse per compare channel and the present count direction, for use by a waveform stage outside the block.

Top module: `pscl_timer`

## Requirements
- R1: After reset every readable register, including the count, reads 0. All interrupt requests and match pulses are low, and the direction output is 1 (up).
- R2: A clock-select value of 0 stops the counter. The count holds for any number of cycles.
- R3: The control register is at address 0: clock select in bits 3:0, PWM A enable in bit 4, PWM B enable in bit 5, clear-on-top in bit 6. A clock select n (1..15) advances the count once every 2^(n-1) input clocks. After a prescaler restart cycle, the first advance happens at the edge that ends the 2^(n-1)-th following cycle.
- R4: The top is the compare C register (address 4) when clear-on-top or either PWM enable is set. Otherwise the top is 255, and compare C has no effect.
- R5: Outside phase-correct mode, a tick with the count at or above the top loads 0 and sets the wrap flag.
- R6: Phase-correct mode is selected when a PWM enable is set and clear-on-top is clear. The count rises to the top, where the direction output goes to 0. It then falls to 0, where the direction returns to 1. The wrap flag is set only on reaching 0.
- R7: When an advance makes the count equal compare A (address 2) or compare B (address 3), the matching flag is set and the match pulse output is high for exactly one cycle.
- R8: The flags register is at address 5: wrap in bit 0, compare A in bit 1, compare B in bit 2. Writing a 1 to a bit clears that flag, and writing 0 leaves it alone. A flag set in the same cycle as its clear stays set.
- R9: A write to the count register (address 1) replaces that cycle's advance and forces the direction to up. A loaded value equal to a compare value raises that match outside phase-correct mode, and raises no match in phase-correct mode.
- R10: Writing 1 to bit 0 at address 7 restarts the prescaler, and so does a control write that changes the clock select. In both cases no advance happens in that cycle.
- R11: Each interrupt request is high exactly when its flag and its mask bit are both set. The mask register is at address 6, with the same bit order as the flags.
- R12: With clear-on-top set, top 249 and clock select 8, the wrap flag sets exactly 32000 cycles after the restarting control write, starting from count 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Register write strobe |
| addr_i | input | 3 | Register address |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Read data for addr_i |
| count_up_o | output | 1 | Count direction, 1 = up |
| match_a_o | output | 1 | One-cycle compare A match pulse |
| match_b_o | output | 1 | One-cycle compare B match pulse |
| irq_ovf_o | output | 1 | Wrap interrupt request |
| irq_cmp_a_o | output | 1 | Compare A interrupt request |
| irq_cmp_b_o | output | 1 | Compare B interrupt request |

## Verification
The bench builds the block with its defaults: an 8-bit count and a 4-bit clock select, which give a 14-bit prescaler. Random traffic keeps the clock select at 1 to 3 and the compare values below 16. This brings wraps, phase-correct turnarounds, top changes made in mid-count, and loads that coincide with ticks or flag clears within a few thousand cycles. Divisor 128 is exercised by a directed full-period run against top 249, and the slowest divisors are covered only by the bit-mask structure that serves every setting.

// File: rtl/pscl_timer_pkg.sv
package pscl_timer_pkg;
  localparam logic [2:0] A_CTRL   = 3'd0;
  localparam logic [2:0] A_COUNT  = 3'd1;
  localparam logic [2:0] A_CMP_A  = 3'd2;
  localparam logic [2:0] A_CMP_B  = 3'd3;
  localparam logic [2:0] A_CMP_C  = 3'd4;
  localparam logic [2:0] A_FLAGS  = 3'd5;
  localparam logic [2:0] A_MASK   = 3'd6;
  localparam logic [2:0] A_STROBE = 3'd7;

  localparam int NUM_EV = 3;

  // bit order matches the flags and mask registers
  typedef struct packed {
    logic hit_b;
    logic hit_a;
    logic wrap;
  } tmr_ev_t;
endpackage

// File: rtl/pscl_prescaler.sv
module pscl_prescaler #(
  parameter int SEL_W = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [SEL_W-1:0] sel_i,
  input  logic             restart_i,
  output logic             tick_o
);
  localparam int PSC_W = (1 << SEL_W) - 2;

  logic [PSC_W-1:0] psc_q;
  logic [PSC_W-1:0] psc_mask;

  // bit i participates when divisor 2^(sel-1) exceeds 2^i
  for (genvar i = 0; i < PSC_W; i++) begin : g_mask
    assign psc_mask[i] = (sel_i > SEL_W'(i + 1));
  end

  assign tick_o = (sel_i != '0) && !restart_i && (&(psc_q | ~psc_mask));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        psc_q <= '0;
    else if (restart_i) psc_q <= '0;
    else                psc_q <= psc_q + PSC_W'(1);
  end
endmodule

// File: rtl/pscl_counter.sv
module pscl_counter
  import pscl_timer_pkg::*;
#(
  parameter int CNT_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             tick_i,
  input  logic             pc_mode_i,
  input  logic [CNT_W-1:0] top_i,
  input  logic [CNT_W-1:0] cmp_a_i,
  input  logic [CNT_W-1:0] cmp_b_i,
  input  logic             load_i,
  input  logic [CNT_W-1:0] load_val_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             up_o,
  output tmr_ev_t          ev_o
);
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             up_q, up_d;
  logic             adv, wrap;
  logic             cmp_en;

  always_comb begin
    cnt_d = cnt_q;
    up_d  = up_q;
    adv   = 1'b0;
    wrap  = 1'b0;
    if (load_i) begin
      cnt_d = load_val_i;
      up_d  = 1'b1;
    end else if (tick_i) begin
      adv = 1'b1;
      if (!pc_mode_i) begin
        up_d = 1'b1;
        if (cnt_q >= top_i) begin
          cnt_d = '0;
          wrap  = 1'b1;
        end else begin
          cnt_d = cnt_q + CNT_W'(1);
        end
      end else if (up_q) begin
        if (({1'b0, cnt_q} + (CNT_W+1)'(1)) >= {1'b0, top_i}) begin
          cnt_d = top_i;
          up_d  = 1'b0;
        end else begin
          cnt_d = cnt_q + CNT_W'(1);
        end
      end else begin
        if (cnt_q <= CNT_W'(1)) begin
          cnt_d = '0;
          up_d  = 1'b1;
          wrap  = 1'b1;
        end else begin
          cnt_d = cnt_q - CNT_W'(1);
        end
      end
    end
  end

  // loads compare only outside phase-correct mode
  assign cmp_en = adv || (load_i && !pc_mode_i);

  assign ev_o.wrap  = wrap;
  assign ev_o.hit_a = cmp_en && (cnt_d == cmp_a_i);
  assign ev_o.hit_b = cmp_en && (cnt_d == cmp_b_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      up_q  <= 1'b1;
    end else begin
      cnt_q <= cnt_d;
      up_q  <= up_d;
    end
  end

  assign cnt_o = cnt_q;
  assign up_o  = up_q;
endmodule

// File: rtl/pscl_flags.sv
module pscl_flags #(
  parameter int N = 3
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [N-1:0] set_i,
  input  logic [N-1:0] clr_i,
  input  logic [N-1:0] mask_i,
  output logic [N-1:0] flags_o,
  output logic [N-1:0] irq_o
);
  logic [N-1:0] flags_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) flags_q <= '0;
    else         flags_q <= (flags_q & ~clr_i) | set_i;  // set wins
  end

  for (genvar i = 0; i < N; i++) begin : g_irq
    assign irq_o[i] = flags_q[i] & mask_i[i];
  end

  assign flags_o = flags_q;
endmodule

// File: rtl/pscl_timer.sv
module pscl_timer
  import pscl_timer_pkg::*;
#(
  parameter int CNT_W = 8,
  parameter int SEL_W = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_en_i,
  input  logic [2:0]       addr_i,
  input  logic [CNT_W-1:0] wdata_i,
  output logic [CNT_W-1:0] rdata_o,
  output logic             count_up_o,
  output logic             match_a_o,
  output logic             match_b_o,
  output logic             irq_ovf_o,
  output logic             irq_cmp_a_o,
  output logic             irq_cmp_b_o
);
  localparam int CTRL_W   = SEL_W + 3;
  localparam int PWM_A_B  = SEL_W;
  localparam int PWM_B_B  = SEL_W + 1;
  localparam int CLR_TOP_B = SEL_W + 2;

  logic [CTRL_W-1:0] ctrl_q;
  logic [CNT_W-1:0]  cmp_a_q, cmp_b_q, cmp_c_q;
  logic [NUM_EV-1:0] mask_q;
  logic              match_a_q, match_b_q;

  logic [SEL_W-1:0]  sel;
  logic              pwm_any, clr_top, pc_mode;
  logic [CNT_W-1:0]  top;
  logic              wr_ctrl, wr_cnt, wr_flags, restart, tick;
  logic [CNT_W-1:0]  cnt;
  logic              up;
  tmr_ev_t           ev;
  logic [NUM_EV-1:0] flags, irq, flag_clr;

  assign sel     = ctrl_q[SEL_W-1:0];
  assign pwm_any = ctrl_q[PWM_A_B] | ctrl_q[PWM_B_B];
  assign clr_top = ctrl_q[CLR_TOP_B];
  assign pc_mode = pwm_any & ~clr_top;
  assign top     = (pwm_any | clr_top) ? cmp_c_q : '1;

  assign wr_ctrl  = wr_en_i && (addr_i == A_CTRL);
  assign wr_cnt   = wr_en_i && (addr_i == A_COUNT);
  assign wr_flags = wr_en_i && (addr_i == A_FLAGS);
  assign restart  = (wr_ctrl && (wdata_i[SEL_W-1:0] != sel)) ||
                    (wr_en_i && (addr_i == A_STROBE) && wdata_i[0]);
  assign flag_clr = wr_flags ? wdata_i[NUM_EV-1:0] : '0;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctrl_q  <= '0;
      cmp_a_q <= '0;
      cmp_b_q <= '0;
      cmp_c_q <= '0;
      mask_q  <= '0;
    end else if (wr_en_i) begin
      case (addr_i)
        A_CTRL:  ctrl_q  <= wdata_i[CTRL_W-1:0];
        A_CMP_A: cmp_a_q <= wdata_i;
        A_CMP_B: cmp_b_q <= wdata_i;
        A_CMP_C: cmp_c_q <= wdata_i;
        A_MASK:  mask_q  <= wdata_i[NUM_EV-1:0];
        default: ;
      endcase
    end
  end

  pscl_prescaler #(.SEL_W(SEL_W)) u_psc (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .sel_i     (sel),
    .restart_i (restart),
    .tick_o    (tick)
  );

  pscl_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .tick_i     (tick),
    .pc_mode_i  (pc_mode),
    .top_i      (top),
    .cmp_a_i    (cmp_a_q),
    .cmp_b_i    (cmp_b_q),
    .load_i     (wr_cnt),
    .load_val_i (wdata_i),
    .cnt_o      (cnt),
    .up_o       (up),
    .ev_o       (ev)
  );

  pscl_flags #(.N(NUM_EV)) u_flags (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .set_i   (ev),
    .clr_i   (flag_clr),
    .mask_i  (mask_q),
    .flags_o (flags),
    .irq_o   (irq)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      match_a_q <= 1'b0;
      match_b_q <= 1'b0;
    end else begin
      match_a_q <= ev.hit_a;
      match_b_q <= ev.hit_b;
    end
  end

  always_comb begin
    case (addr_i)
      A_CTRL:  rdata_o = CNT_W'(ctrl_q);
      A_COUNT: rdata_o = cnt;
      A_CMP_A: rdata_o = cmp_a_q;
      A_CMP_B: rdata_o = cmp_b_q;
      A_CMP_C: rdata_o = cmp_c_q;
      A_FLAGS: rdata_o = CNT_W'(flags);
      A_MASK:  rdata_o = CNT_W'(mask_q);
      default: rdata_o = '0;
    endcase
  end

  assign count_up_o  = up;
  assign match_a_o   = match_a_q;
  assign match_b_o   = match_b_q;
  assign irq_ovf_o   = irq[0];
  assign irq_cmp_a_o = irq[1];
  assign irq_cmp_b_o = irq[2];
endmodule

// File: rtl/pscl_timer_chk.sv
module pscl_timer_chk
  import pscl_timer_pkg::*;
#(
  parameter int CNT_W = 8,
  parameter int SEL_W = 4
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             wr_en_i,
  input logic [2:0]       addr_i,
  input logic [CNT_W-1:0] wdata_i,
  input logic [SEL_W-1:0] sel_i,
  input logic             tick_i,
  input logic             pc_mode_i,
  input logic [CNT_W-1:0] top_i,
  input logic [CNT_W-1:0] cnt_i,
  input logic             up_i,
  input logic [2:0]       ev_i,
  input logic [2:0]       flags_i,
  input logic             match_a_i,
  input logic             match_b_i,
  input logic             irq_ovf_i
);
  logic load;
  assign load = wr_en_i && (addr_i == A_COUNT);

  assert_stop_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sel_i == '0 && !load) |=> (cnt_i == $past(cnt_i)));

  assert_wrap_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick_i && !pc_mode_i && !load && cnt_i >= top_i) |=> (cnt_i == '0 && flags_i[0]));

  assert_pc_bottom_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick_i && pc_mode_i && !load && !up_i && cnt_i <= CNT_W'(1))
      |=> (cnt_i == '0 && up_i && flags_i[0]));

  assert_pc_peak_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick_i && pc_mode_i && !load && up_i &&
     (({1'b0, cnt_i} + (CNT_W+1)'(1)) >= {1'b0, top_i}))
      |=> (!up_i && cnt_i == $past(top_i)));

  assert_match_a_flag_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    match_a_i |-> flags_i[1]);

  assert_match_b_flag_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    match_b_i |-> flags_i[2]);

  assert_w1c_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && addr_i == A_FLAGS && wdata_i[0] && !ev_i[0]) |=> !flags_i[0]);

  assert_load_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load |=> (cnt_i == $past(wdata_i) && up_i));

  assert_irq_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_ovf_i |-> flags_i[0]);
endmodule

bind pscl_timer pscl_timer_chk #(.CNT_W(CNT_W), .SEL_W(SEL_W)) u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .wr_en_i   (wr_en_i),
  .addr_i    (addr_i),
  .wdata_i   (wdata_i),
  .sel_i     (sel),
  .tick_i    (tick),
  .pc_mode_i (pc_mode),
  .top_i     (top),
  .cnt_i     (cnt),
  .up_i      (up),
  .ev_i      (ev),
  .flags_i   (flags),
  .match_a_i (match_a_o),
  .match_b_i (match_b_o),
  .irq_ovf_i (irq_ovf_o)
);

// File: tb/pscl_timer_bench.sv
module pscl_timer_bench;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       wr_en_i = 1'b0;
  logic [2:0] addr_i = 3'd0;
  logic [7:0] wdata_i = 8'd0;
  logic [7:0] rdata_o;
  logic count_up_o, match_a_o, match_b_o, irq_ovf_o, irq_cmp_a_o, irq_cmp_b_o;

  int n_checks = 0;
  int n_fails  = 0;
  bit done     = 1'b0;

  // reference model state
  int m_ctrl, m_cnt, m_up, m_psc, m_ca, m_cb, m_cc, m_flags, m_mask, m_ma, m_mb;

  pscl_timer u_pscl_timer (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .wr_en_i     (wr_en_i),
    .addr_i      (addr_i),
    .wdata_i     (wdata_i),
    .rdata_o     (rdata_o),
    .count_up_o  (count_up_o),
    .match_a_o   (match_a_o),
    .match_b_o   (match_b_o),
    .irq_ovf_o   (irq_ovf_o),
    .irq_cmp_a_o (irq_cmp_a_o),
    .irq_cmp_b_o (irq_cmp_b_o)
  );

  always #10 clk_i = ~clk_i;

  task automatic check(string req, int act, int exp);
    n_checks++;
    if (act != exp) begin
      n_fails++;
      $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
    end
  endtask

  function automatic int div_mask(int sel);
    return (sel == 0) ? 0 : ((1 << (sel - 1)) - 1);
  endfunction

  function automatic int top_of(int ctrl, int cc);
    return ((ctrl & 'h70) != 0) ? cc : 255;
  endfunction

  function automatic bit pc_of(int ctrl);
    return ((ctrl & 'h30) != 0) && ((ctrl & 'h40) == 0);
  endfunction

  task automatic model_step(bit wr, int a, int d);
    int sel, topv, nc, nu, set_b, clr, msk;
    bit pc, restart, tick, load, adv, wrap;
    sel  = m_ctrl & 15;
    pc   = pc_of(m_ctrl);
    topv = top_of(m_ctrl, m_cc);
    msk  = div_mask(sel);
    restart = wr && ((a == 0 && (d & 15) != sel) || (a == 7 && d[0]));
    tick = (sel != 0) && !restart && ((m_psc & msk) == msk);
    load = wr && a == 1;
    nc = m_cnt; nu = m_up; adv = 0; wrap = 0;
    if (load) begin nc = d; nu = 1; end
    else if (tick) begin
      adv = 1;
      if (!pc) begin
        nu = 1;
        if (m_cnt >= topv) begin nc = 0; wrap = 1; end else nc = m_cnt + 1;
      end else if (m_up != 0) begin
        if (m_cnt + 1 >= topv) begin nc = topv; nu = 0; end else nc = m_cnt + 1;
      end else begin
        if (m_cnt <= 1) begin nc = 0; nu = 1; wrap = 1; end else nc = m_cnt - 1;
      end
    end
    m_ma = ((adv || (load && !pc)) && nc == m_ca) ? 1 : 0;
    m_mb = ((adv || (load && !pc)) && nc == m_cb) ? 1 : 0;
    set_b = (wrap ? 1 : 0) | (m_ma << 1) | (m_mb << 2);
    clr = (wr && a == 5) ? (d & 7) : 0;
    m_flags = ((m_flags & ~clr) | set_b) & 7;
    m_cnt = nc; m_up = nu;
    if (wr) begin
      case (a)
        0: m_ctrl = d & 'h7f;
        2: m_ca = d;
        3: m_cb = d;
        4: m_cc = d;
        6: m_mask = d & 7;
        default: ;
      endcase
    end
    m_psc = restart ? 0 : ((m_psc + 1) & 16383);
  endtask

  task automatic rd(input logic [2:0] a, output int v);
    addr_i = a;
    #1;
    v = rdata_o;
  endtask

  task automatic compare_model();
    int v;
    rd(3'd1, v); check("R3 R5 R6 model count", v, m_cnt);
    rd(3'd5, v); check("R7 R8 model flags", v, m_flags);
    check("R6 model direction", count_up_o, m_up);
    check("R7 model match a", match_a_o, m_ma);
    check("R7 model match b", match_b_o, m_mb);
    check("R11 model irq", {irq_cmp_b_o, irq_cmp_a_o, irq_ovf_o}, m_flags & m_mask);
  endtask

  // called at negedge; leaves the bench at the following negedge
  task automatic cyc(bit wr, int a, int d);
    wr_en_i = wr;
    addr_i  = a[2:0];
    wdata_i = d[7:0];
    model_step(wr, a, d);
    @(posedge clk_i);
    @(negedge clk_i);
    wr_en_i = 1'b0;
    compare_model();
  endtask

  task automatic wr(int a, int d);
    cyc(1'b1, a, d);
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) cyc(1'b0, 0, 0);
  endtask

  initial begin
    #(20 * 200000);
    if (!done) begin
      n_checks++;
      n_fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
      $finish;
    end
  end

  initial begin
    int v, c0;
    int seq_c[7];
    int seq_u[7];
    int seq_o[7];
    m_ctrl = 0; m_cnt = 0; m_up = 1; m_psc = 0; m_ca = 0; m_cb = 0; m_cc = 0;
    m_flags = 0; m_mask = 0; m_ma = 0; m_mb = 0;
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;

    // R1 reset state
    for (int a = 0; a < 8; a++) begin
      rd(a[2:0], v); check("R1 register after reset", v, 0);
    end
    check("R1 direction after reset", count_up_o, 1);
    check("R1 irqs after reset", {irq_cmp_b_o, irq_cmp_a_o, irq_ovf_o}, 0);
    check("R1 matches after reset", {match_b_o, match_a_o}, 0);

    // R2 stopped
    idle(40);
    rd(3'd1, v); check("R2 count with select 0", v, 0);

    // R3 divide by 8
    wr(0, 4);
    idle(7);
    rd(3'd1, v); check("R3 no advance before 8 cycles", v, 0);
    idle(1);
    rd(3'd1, v); check("R3 first advance at cycle 8", v, 1);
    idle(8);
    rd(3'd1, v); check("R3 second advance", v, 2);

    // R10 strobe restart
    idle(3);
    rd(3'd1, c0);
    wr(7, 1);
    rd(3'd1, v); check("R10 no advance in strobe cycle", v, c0);
    idle(7);
    rd(3'd1, v); check("R10 held 7 cycles after strobe", v, c0);
    idle(1);
    rd(3'd1, v); check("R10 advance 8 cycles after strobe", v, c0 + 1);

    // R5 wrap at top 9
    wr(0, 0);
    wr(4, 9);
    wr(1, 9);
    wr(5, 7);
    wr(0, 'h41);
    idle(1);
    rd(3'd1, v); check("R5 count wraps to 0", v, 0);
    rd(3'd5, v); check("R5 wrap flag set", v & 1, 1);

    // R4 top 255 without mode bits, compare C ignored
    wr(0, 1);
    wr(5, 7);
    wr(1, 250);
    idle(5);
    rd(3'd1, v); check("R4 reaches 255 past compare C", v, 255);
    rd(3'd5, v); check("R4 no wrap before 255", v & 1, 0);
    idle(1);
    rd(3'd1, v); check("R4 wraps after 255", v, 0);
    rd(3'd5, v); check("R4 wrap flag", v & 1, 1);

    // R7 compare matches
    wr(2, 5);
    wr(3, 8);
    wr(5, 7);
    wr(1, 4);
    idle(1);
    rd(3'd1, v); check("R7 count at compare A", v, 5);
    check("R7 match a pulse", match_a_o, 1);
    rd(3'd5, v); check("R7 flags after A", v, 2);
    idle(1);
    check("R7 match a one cycle", match_a_o, 0);
    idle(2);
    check("R7 match b pulse", match_b_o, 1);
    rd(3'd5, v); check("R7 flags after B", v, 6);

    // R8 write-one-to-clear
    wr(5, 0);
    rd(3'd5, v); check("R8 write 0 keeps flags", v, 6);
    wr(5, 2);
    rd(3'd5, v); check("R8 write 1 clears A only", v, 4);

    // R11 masks
    wr(6, 4);
    check("R11 irq b with mask", irq_cmp_b_o, 1);
    check("R11 irq a without flag", irq_cmp_a_o, 0);
    wr(6, 0);
    check("R11 irq b masked", irq_cmp_b_o, 0);
    rd(3'd5, v); check("R11 flag b still set", v & 4, 4);

    // R6 phase-correct triangle, top 3
    wr(0, 0);
    wr(5, 7);
    wr(4, 3);
    wr(2, 200);
    wr(3, 200);
    wr(1, 0);
    wr(0, 'h11);
    seq_c = '{1, 2, 3, 2, 1, 0, 1};
    seq_u = '{1, 1, 0, 0, 0, 1, 1};
    seq_o = '{0, 0, 0, 0, 0, 1, 1};
    for (int i = 0; i < 7; i++) begin
      idle(1);
      rd(3'd1, v); check("R6 triangle count", v, seq_c[i]);
      check("R6 triangle direction", count_up_o, seq_u[i]);
      rd(3'd5, v); check("R6 wrap only at bottom", v & 1, seq_o[i]);
    end

    // R9 load in phase-correct mode
    idle(2);
    check("R9 counting down before load", count_up_o, 0);
    wr(2, 2);
    wr(5, 7);
    wr(1, 2);
    rd(3'd1, v); check("R9 load value", v, 2);
    check("R9 load forces up", count_up_o, 1);
    check("R9 no match on load in phase-correct", match_a_o, 0);
    rd(3'd5, v); check("R9 no flag on load in phase-correct", v & 2, 0);
    idle(2);
    check("R9 later phase-correct match", match_a_o, 1);
    // R9 load outside phase-correct
    wr(5, 7);
    wr(0, 'h41);
    rd(3'd5, v); check("R9 flag A clear before load", v & 2, 0);
    wr(1, 2);
    check("R9 match on load outside phase-correct", match_a_o, 1);
    rd(3'd5, v); check("R9 flag A on load", v & 2, 2);

    // R12 full period, divisor 128, top 249
    wr(0, 0);
    wr(4, 249);
    wr(1, 0);
    wr(5, 7);
    wr(0, 'h48);
    idle(31999);
    rd(3'd5, v); check("R12 no wrap at 31999", v & 1, 0);
    idle(1);
    rd(3'd5, v); check("R12 wrap at 32000", v & 1, 1);
    rd(3'd1, v); check("R12 count 0 at wrap", v, 0);

    // random traffic against the model
    wr(0, 1);
    for (int i = 0; i < 4000; i++) begin
      int r;
      r = $urandom % 100;
      if (r < 6)       wr(0, (($urandom % 8) << 4) | (1 + $urandom % 3));
      else if (r < 10) wr(1, $urandom % 16);
      else if (r < 14) wr(2 + ($urandom % 3), $urandom % 16);
      else if (r < 18) wr(5, $urandom % 8);
      else if (r < 20) wr(6, $urandom % 8);
      else if (r < 22) wr(7, $urandom % 2);
      else             idle(1);
    end

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
    $finish;
  end
endmodule